// File: doc/BRIEF.md
# USB Endpoint Buffer Handshake Controller

This block keeps track of who owns each endpoint buffer of a USB device and picks the handshake the device returns for every token. The device engine reports each token as a kind (OUT, IN or SETUP) together with an endpoint index. One cycle later the block answers with ACK, NAK, STALL or no handshake, and with the data PID (DATA0 or DATA1) that the transfer uses.

Firmware uses a small command port. A one-cycle strobe carries an 8-bit opcode, an endpoint index and a write byte. The port frees received OUT buffers, arms IN buffers for sending, writes the per-endpoint control bits and reads the endpoint state. Opcodes that return a byte raise a one-cycle ready pulse together with the byte.

Control endpoint 0 has three extra pieces of state:
- SETUP packets are always taken, and taking one may overwrite unread data. A sticky flag records that this happened.
- A setup-pending flag records that a SETUP has arrived and not yet been acknowledged.
- A conditional stall halts both directions of endpoint 0 until a SETUP arrives.

Interrupt-style endpoints can be switched to a rate-feedback mode, in which no data toggle is used.

Top module: `usb_ep_handshake`

## Requirements
- R1: After synchronous reset every flag, toggle and control bit is 0, and the outputs rsp_valid, rsp_code, rsp_dpid, cmd_rdy and cmd_rdata are all 0.
- R2: An OUT token that is accepted (ACK) sets the buffer-full flag of its endpoint. While that flag is set, each further OUT token to that endpoint gets NAK.
- R3: Opcode 0xF2 clears the buffer-full flag of the selected endpoint. One cycle later cmd_rdy pulses, and cmd_rdata bit 0 holds the overwrite flag when the endpoint is 0 (otherwise 0). Bits 7:1 of cmd_rdata are 0.
- R4: A SETUP token on endpoint 0 gets ACK with DATA0 whatever the state of the buffer. It sets the buffer-full and setup-pending flags. If the buffer was already full, it also sets the overwrite flag. A SETUP token on any other endpoint gets no handshake.
- R5: The overwrite flag stays set through any number of 0xF2 commands. Only opcode 0x41 on endpoint 0 clears it.
- R6: Opcode 0xFA arms the IN buffer of the selected endpoint and returns no byte. An IN token on an armed buffer gets ACK and disarms it. An IN token on a buffer that is not armed gets NAK.
- R7: Opcode 0x40 writes the control bits from cmd_wdata:
  - bit 0: stall
  - bit 5: disable
  - bit 6: rate-feedback
  - bit 7: conditional stall, taken only when the endpoint is 0

  While the disable bit is set, every token to that endpoint gets no handshake (code 0) and changes no state.
- R8: An endpoint with its stall bit set answers OUT and IN tokens with STALL, and stall takes priority over NAK. A SETUP token on endpoint 0 is still acknowledged and clears that endpoint's stall bit.
- R9: While the conditional stall is set and setup-pending is clear, OUT and IN tokens on endpoint 0 get STALL. Once a SETUP has set setup-pending they are handled normally, until opcode 0x41 on endpoint 0 clears setup-pending again.
- R10: In toggle mode, each acknowledged OUT or IN transfer reports the current toggle of its direction as rsp_dpid (0 means DATA0) and then inverts that toggle. An acknowledged SETUP sets both toggles of endpoint 0 to 1.
- R11: In rate-feedback mode, acknowledged OUT and IN transfers report DATA0 and leave the toggle unchanged.
- R12: rsp_valid pulses exactly one cycle after each tok_valid. rsp_code is encoded as 0 = none, 1 = ACK, 2 = NAK, 3 = STALL. cmd_rdy pulses one cycle after opcode 0xF2 or 0x41 and after no other opcode.
- R13: Opcode 0x41 returns a byte whose bits are:
  - bit 0: buffer-full
  - bit 1: effective stall
  - bit 2: setup-pending (endpoint 0 only)
  - bit 3: overwrite (endpoint 0 only)
  - bit 4: IN armed
  - bits 7:5: 0

  The byte is taken before the command has any effect. The command then clears setup-pending and overwrite when the endpoint is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_valid | input | 1 | Token event strobe |
| tok_kind | input | 2 | 0 = OUT, 1 = IN, 2 = SETUP |
| tok_ep | input | EPW | Endpoint index of the token |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command opcode |
| cmd_ep | input | EPW | Selected endpoint |
| cmd_wdata | input | 8 | Write byte for opcode 0x40 |
| rsp_valid | output | 1 | Handshake decision valid |
| rsp_code | output | 2 | 0 none, 1 ACK, 2 NAK, 3 STALL |
| rsp_dpid | output | 1 | Data PID of an acknowledged transfer (1 = DATA1) |
| cmd_rdy | output | 1 | Read byte valid |
| cmd_rdata | output | 8 | Read byte |

## Verification
The assertions assume that a token event and a command never arrive in the same cycle. Because of this, each flag change comes from exactly one source per clock. The assertions also assume that endpoint indexes stay below NUM_EP. The stimulus drives every token or command through a task that leaves the other port idle, and it uses only indexes 0 to 3 with the default of four endpoints. Undefined opcodes and the unused token kind are sent only on their own, so the checks that they are ignored still respect these assumptions.

// File: rtl/ep_hs_pkg.sv
package ep_hs_pkg;

  typedef enum logic [1:0] {
    TK_OUT   = 2'd0,
    TK_IN    = 2'd1,
    TK_SETUP = 2'd2
  } tok_kind_e;

  typedef enum logic [1:0] {
    HS_NONE  = 2'd0,
    HS_ACK   = 2'd1,
    HS_NAK   = 2'd2,
    HS_STALL = 2'd3
  } hs_e;

  localparam logic [7:0] OP_CLRBUF   = 8'hF2;
  localparam logic [7:0] OP_VALIDATE = 8'hFA;
  localparam logic [7:0] OP_SETSTAT  = 8'h40;
  localparam logic [7:0] OP_SELCLR   = 8'h41;

  // Effect of one token on the endpoint state
  typedef struct packed {
    logic set_full;
    logic setup_hit;
    logic clr_armed;
    logic flip_out;
    logic flip_in;
  } tok_eff_t;

  // Decoded command actions
  typedef struct packed {
    logic clrbuf;
    logic validate;
    logic setstat;
    logic selclr;
  } cmd_act_t;

endpackage

// File: rtl/ep_hs_decide.sv
module ep_hs_decide
  import ep_hs_pkg::*;
#(
  parameter int NUM_EP = 4,
  localparam int EPW = $clog2(NUM_EP)
) (
  input  logic [1:0]        kind,
  input  logic [EPW-1:0]    ep,
  input  logic [NUM_EP-1:0] full,
  input  logic [NUM_EP-1:0] armed,
  input  logic [NUM_EP-1:0] stall,
  input  logic [NUM_EP-1:0] dis,
  input  logic [NUM_EP-1:0] rfb,
  input  logic [NUM_EP-1:0] out_tog,
  input  logic [NUM_EP-1:0] in_tog,
  input  logic              stp0,
  input  logic              cstall0,
  output hs_e               code,
  output logic              dpid,
  output tok_eff_t          eff
);

  logic is_ep0;
  logic halt;

  always_comb begin
    is_ep0 = (ep == '0);
    halt   = stall[ep] | (is_ep0 & cstall0 & ~stp0);
    code   = HS_NONE;
    dpid   = 1'b0;
    eff    = '0;
    if (!dis[ep]) begin
      case (kind)
        TK_SETUP: begin
          if (is_ep0) begin
            code          = HS_ACK;
            eff.setup_hit = 1'b1;
          end
        end
        TK_OUT: begin
          if (halt) begin
            code = HS_STALL;
          end else if (full[ep]) begin
            code = HS_NAK;
          end else begin
            code         = HS_ACK;
            dpid         = ~rfb[ep] & out_tog[ep];
            eff.set_full = 1'b1;
            eff.flip_out = ~rfb[ep];
          end
        end
        TK_IN: begin
          if (halt) begin
            code = HS_STALL;
          end else if (!armed[ep]) begin
            code = HS_NAK;
          end else begin
            code          = HS_ACK;
            dpid          = ~rfb[ep] & in_tog[ep];
            eff.clr_armed = 1'b1;
            eff.flip_in   = ~rfb[ep];
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ep_hs_bank.sv
module ep_hs_bank
  import ep_hs_pkg::*;
#(
  parameter int NUM_EP = 4,
  localparam int EPW = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tok_fire,
  input  logic [EPW-1:0]    tok_ep,
  input  tok_eff_t          eff,
  input  cmd_act_t          act,
  input  logic [EPW-1:0]    cmd_ep,
  input  logic [7:0]        wdata,
  output logic [NUM_EP-1:0] full,
  output logic [NUM_EP-1:0] armed,
  output logic [NUM_EP-1:0] stall,
  output logic [NUM_EP-1:0] dis,
  output logic [NUM_EP-1:0] rfb,
  output logic [NUM_EP-1:0] out_tog,
  output logic [NUM_EP-1:0] in_tog,
  output logic              po0,
  output logic              stp0,
  output logic              cstall0
);

  logic unused_wd;
  assign unused_wd = ^wdata[4:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      full    <= '0;
      armed   <= '0;
      stall   <= '0;
      dis     <= '0;
      rfb     <= '0;
      out_tog <= '0;
      in_tog  <= '0;
    end else begin
      for (int i = 0; i < NUM_EP; i++) begin
        if (tok_fire && tok_ep == EPW'(i)) begin
          if (eff.set_full)  full[i]    <= 1'b1;
          if (eff.clr_armed) armed[i]   <= 1'b0;
          if (eff.flip_out)  out_tog[i] <= ~out_tog[i];
          if (eff.flip_in)   in_tog[i]  <= ~in_tog[i];
          if (eff.setup_hit) begin
            full[i]    <= 1'b1;
            out_tog[i] <= 1'b1;
            in_tog[i]  <= 1'b1;
            stall[i]   <= 1'b0;
          end
        end
        if (cmd_ep == EPW'(i)) begin
          if (act.clrbuf)   full[i]  <= 1'b0;
          if (act.validate) armed[i] <= 1'b1;
          if (act.setstat) begin
            stall[i] <= wdata[0];
            dis[i]   <= wdata[5];
            rfb[i]   <= wdata[6];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      po0     <= 1'b0;
      stp0    <= 1'b0;
      cstall0 <= 1'b0;
    end else begin
      if (tok_fire && eff.setup_hit) begin
        po0  <= po0 | full[0];
        stp0 <= 1'b1;
      end
      if (act.selclr && cmd_ep == '0) begin
        po0  <= 1'b0;
        stp0 <= 1'b0;
      end
      if (act.setstat && cmd_ep == '0) cstall0 <= wdata[7];
    end
  end

  AST_PO_STICKY: assert property (@(posedge clk) disable iff (rst)
    (po0 && !(act.selclr && cmd_ep == '0)) |=> po0); // R5

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (full[0] && !(act.clrbuf && cmd_ep == '0)) |=> full[0]); // R2

endmodule

// File: rtl/ep_hs_cmd.sv
module ep_hs_cmd
  import ep_hs_pkg::*;
#(
  parameter int NUM_EP = 4,
  localparam int EPW = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  input  logic [EPW-1:0]    cmd_ep,
  input  logic [NUM_EP-1:0] full,
  input  logic [NUM_EP-1:0] armed,
  input  logic [NUM_EP-1:0] stall,
  input  logic              po0,
  input  logic              stp0,
  input  logic              cstall0,
  output cmd_act_t          act,
  output logic              rdy,
  output logic [7:0]        rdata
);

  logic sel0;
  logic halt;

  always_comb begin
    act.clrbuf   = cmd_valid && cmd_code == OP_CLRBUF;
    act.validate = cmd_valid && cmd_code == OP_VALIDATE;
    act.setstat  = cmd_valid && cmd_code == OP_SETSTAT;
    act.selclr   = cmd_valid && cmd_code == OP_SELCLR;
    sel0         = (cmd_ep == '0);
    halt         = stall[cmd_ep] | (sel0 & cstall0 & ~stp0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy   <= 1'b0;
      rdata <= '0;
    end else begin
      rdy   <= act.clrbuf | act.selclr;
      rdata <= '0;
      if (act.clrbuf) rdata <= {7'b0, sel0 & po0};
      if (act.selclr) rdata <= {3'b0, armed[cmd_ep], sel0 & po0, sel0 & stp0,
                                halt, full[cmd_ep]};
    end
  end

  AST_RDY_ONLY_READS: assert property (@(posedge clk) disable iff (rst)
    rdy |-> ($past(cmd_valid) &&
             ($past(cmd_code) == OP_CLRBUF || $past(cmd_code) == OP_SELCLR))); // R12

  AST_CLR_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rdy && $past(cmd_code) == OP_CLRBUF) |-> rdata[7:1] == 7'd0); // R3

endmodule

// File: rtl/usb_ep_handshake.sv
module usb_ep_handshake
  import ep_hs_pkg::*;
#(
  parameter int NUM_EP = 4,
  localparam int EPW = $clog2(NUM_EP)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tok_valid,
  input  logic [1:0]     tok_kind,
  input  logic [EPW-1:0] tok_ep,
  input  logic           cmd_valid,
  input  logic [7:0]     cmd_code,
  input  logic [EPW-1:0] cmd_ep,
  input  logic [7:0]     cmd_wdata,
  output logic           rsp_valid,
  output logic [1:0]     rsp_code,
  output logic           rsp_dpid,
  output logic           cmd_rdy,
  output logic [7:0]     cmd_rdata
);

  logic [NUM_EP-1:0] full, armed, stall, dis, rfb, out_tog, in_tog;
  logic              po0, stp0, cstall0;
  hs_e               code_c;
  logic              dpid_c;
  tok_eff_t          eff;
  cmd_act_t          act;

  ep_hs_decide #(.NUM_EP(NUM_EP)) u_decide (
    .kind(tok_kind), .ep(tok_ep), .full(full), .armed(armed), .stall(stall),
    .dis(dis), .rfb(rfb), .out_tog(out_tog), .in_tog(in_tog), .stp0(stp0),
    .cstall0(cstall0), .code(code_c), .dpid(dpid_c), .eff(eff)
  );

  ep_hs_cmd #(.NUM_EP(NUM_EP)) u_cmd (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_ep(cmd_ep), .full(full), .armed(armed), .stall(stall), .po0(po0),
    .stp0(stp0), .cstall0(cstall0), .act(act), .rdy(cmd_rdy), .rdata(cmd_rdata)
  );

  ep_hs_bank #(.NUM_EP(NUM_EP)) u_bank (
    .clk(clk), .rst(rst), .tok_fire(tok_valid), .tok_ep(tok_ep), .eff(eff),
    .act(act), .cmd_ep(cmd_ep), .wdata(cmd_wdata), .full(full), .armed(armed),
    .stall(stall), .dis(dis), .rfb(rfb), .out_tog(out_tog), .in_tog(in_tog),
    .po0(po0), .stp0(stp0), .cstall0(cstall0)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_code  <= 2'd0;
      rsp_dpid  <= 1'b0;
    end else begin
      rsp_valid <= tok_valid;
      rsp_code  <= tok_valid ? code_c : HS_NONE;
      rsp_dpid  <= tok_valid & dpid_c;
    end
  end

  AST_RSP_FOLLOWS_TOK: assert property (@(posedge clk) disable iff (rst)
    tok_valid |=> rsp_valid); // R12

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
    !tok_valid |=> (!rsp_valid && rsp_code == 2'd0)); // R12

  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && dis[tok_ep]) |=> rsp_code == 2'd0); // R7

  AST_SETUP_ALWAYS_ACK: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && tok_kind == 2'd2 && tok_ep == '0 && !dis[0])
      |=> (rsp_code == 2'd1 && !rsp_dpid)); // R4

  AST_FULL_REFUSES_OUT: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && tok_kind == 2'd0 && full[tok_ep] && !dis[tok_ep])
      |=> rsp_code != 2'd1); // R2

endmodule

// File: tb/sim_usb_ep_handshake.sv
`timescale 1ns/100ps
module sim_usb_ep_handshake;

  localparam int NEP = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tok_valid = 1'b0;
  logic [1:0] tok_kind = 2'd0;
  logic [1:0] tok_ep = 2'd0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_code = 8'd0;
  logic [1:0] cmd_ep = 2'd0;
  logic [7:0] cmd_wdata = 8'd0;
  logic       rsp_valid, rsp_dpid, cmd_rdy;
  logic [1:0] rsp_code;
  logic [7:0] cmd_rdata;

  always #2.5 clk = ~clk;

  usb_ep_handshake #(.NUM_EP(NEP)) u0 (
    .clk(clk), .rst(rst), .tok_valid(tok_valid), .tok_kind(tok_kind),
    .tok_ep(tok_ep), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_ep(cmd_ep), .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid),
    .rsp_code(rsp_code), .rsp_dpid(rsp_dpid), .cmd_rdy(cmd_rdy),
    .cmd_rdata(cmd_rdata)
  );

  int errors = 0;
  int checks = 0;

  // behavioural reference state
  int m_full[NEP], m_arm[NEP], m_stall[NEP], m_dis[NEP], m_rf[NEP];
  int m_otog[NEP], m_itog[NEP];
  int m_po = 0, m_stp = 0, m_cst = 0;

  // expectations for the outputs after the coming clock edge
  int x_valid, x_code, x_dpid, x_rdy, x_rdata;
  string tag;

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic clear_exp();
    x_valid = 0; x_code = 0; x_dpid = 0; x_rdy = 0; x_rdata = 0;
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
    chk("rsp_valid", rsp_valid, x_valid);
    chk("rsp_code", rsp_code, x_code);
    chk("rsp_dpid", rsp_dpid, x_dpid);
    chk("cmd_rdy", cmd_rdy, x_rdy);
    chk("cmd_rdata", cmd_rdata, x_rdata);
    tok_valid = 1'b0;
    cmd_valid = 1'b0;
    clear_exp();
  endtask

  function automatic int halted(int ep);
    return (m_stall[ep] != 0 || (ep == 0 && m_cst != 0 && m_stp == 0)) ? 1 : 0;
  endfunction

  task automatic do_tok(string t, int kind, int ep);
    int se;
    tag = t;
    tok_valid = 1'b1; tok_kind = kind[1:0]; tok_ep = ep[1:0];
    x_valid = 1; x_code = 0; x_dpid = 0;
    se = halted(ep);
    if (m_dis[ep] == 0) begin
      if (kind == 2) begin
        if (ep == 0) begin
          x_code = 1;
          if (m_full[0] != 0) m_po = 1;
          m_stp = 1; m_full[0] = 1; m_otog[0] = 1; m_itog[0] = 1; m_stall[0] = 0;
        end
      end else if (kind == 0) begin
        if (se != 0) x_code = 3;
        else if (m_full[ep] != 0) x_code = 2;
        else begin
          x_code = 1;
          x_dpid = (m_rf[ep] != 0) ? 0 : m_otog[ep];
          m_full[ep] = 1;
          if (m_rf[ep] == 0) m_otog[ep] = 1 - m_otog[ep];
        end
      end else if (kind == 1) begin
        if (se != 0) x_code = 3;
        else if (m_arm[ep] == 0) x_code = 2;
        else begin
          x_code = 1;
          x_dpid = (m_rf[ep] != 0) ? 0 : m_itog[ep];
          m_arm[ep] = 0;
          if (m_rf[ep] == 0) m_itog[ep] = 1 - m_itog[ep];
        end
      end
    end
    cycle();
  endtask

  task automatic do_cmd(string t, int code, int ep, int wd);
    tag = t;
    cmd_valid = 1'b1; cmd_code = code[7:0]; cmd_ep = ep[1:0]; cmd_wdata = wd[7:0];
    case (code)
      'hF2: begin
        x_rdy = 1;
        x_rdata = (ep == 0) ? m_po : 0;
        m_full[ep] = 0;
      end
      'hFA: m_arm[ep] = 1;
      'h40: begin
        m_stall[ep] = wd & 1;
        m_dis[ep] = (wd >> 5) & 1;
        m_rf[ep] = (wd >> 6) & 1;
        if (ep == 0) m_cst = (wd >> 7) & 1;
      end
      'h41: begin
        x_rdy = 1;
        x_rdata = m_full[ep] + 2 * halted(ep) + ((ep == 0) ? 4 * m_stp + 8 * m_po : 0)
                  + 16 * m_arm[ep];
        if (ep == 0) begin m_po = 0; m_stp = 0; end
      end
      default: ;
    endcase
    cycle();
  endtask

  task automatic idle(string t);
    tag = t;
    cycle();
  endtask

  localparam int K_OUT = 0, K_IN = 1, K_SET = 2;

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NEP; i++) begin
      m_full[i] = 0; m_arm[i] = 0; m_stall[i] = 0; m_dis[i] = 0;
      m_rf[i] = 0; m_otog[i] = 0; m_itog[i] = 0;
    end
    clear_exp();
    // R1: reset state
    for (int i = 0; i < 3; i++) idle("R1 reset");
    rst = 1'b0;
    idle("R1 idle");
    do_tok("R1 fresh IN NAK", K_IN, 1);
    // R2 buffer full
    do_tok("R2 OUT accepted", K_OUT, 1);
    do_tok("R2 OUT refused", K_OUT, 1);
    do_tok("R2 OUT refused again", K_OUT, 1);
    // R3 clear buffer
    do_cmd("R3 clear ep1", 'hF2, 1, 0);
    do_tok("R10 OUT DATA1", K_OUT, 1);
    do_cmd("R3 clear ep1 again", 'hF2, 1, 0);
    // R4 setup overwrite
    do_tok("R4 OUT ep0 fills", K_OUT, 0);
    do_tok("R4 SETUP over full", K_SET, 0);
    do_tok("R4 SETUP ep2 silent", K_SET, 2);
    do_tok("R4 OUT ep2 after SETUP", K_OUT, 2);
    // R5 sticky overwrite
    do_cmd("R5 clear shows overwrite", 'hF2, 0, 0);
    do_cmd("R5 overwrite stays", 'hF2, 0, 0);
    do_cmd("R13 select/clear ep0", 'h41, 0, 0);
    do_cmd("R5 overwrite cleared", 'hF2, 0, 0);
    do_cmd("R13 select/clear ep2", 'h41, 2, 0);
    // R6 IN validate
    do_cmd("R6 validate ep1 no byte", 'hFA, 1, 0);
    do_cmd("R13 armed visible", 'h41, 1, 0);
    do_tok("R6 IN sends", K_IN, 1);
    do_tok("R6 IN after send NAK", K_IN, 1);
    do_cmd("R6 validate again", 'hFA, 1, 0);
    do_tok("R10 IN DATA1", K_IN, 1);
    // R10 setup resets toggles
    do_tok("R10 SETUP ep0", K_SET, 0);
    do_cmd("R10 arm ep0", 'hFA, 0, 0);
    do_tok("R10 IN ep0 DATA1", K_IN, 0);
    do_cmd("R10 free ep0", 'hF2, 0, 0);
    do_tok("R10 OUT ep0 DATA1", K_OUT, 0);
    do_cmd("R10 free ep0 again", 'hF2, 0, 0);
    do_tok("R10 OUT ep0 DATA0", K_OUT, 0);
    do_cmd("R13 tidy ep0", 'h41, 0, 0);
    // R7 disable
    do_cmd("R7 disable ep3", 'h40, 3, 'h20);
    do_tok("R7 OUT disabled", K_OUT, 3);
    do_tok("R7 IN disabled", K_IN, 3);
    do_cmd("R7 enable ep3", 'h40, 3, 'h00);
    do_cmd("R7 no state change", 'h41, 3, 0);
    do_tok("R7 OUT after enable", K_OUT, 3);
    // R8 stall
    do_cmd("R8 stall ep2", 'h40, 2, 'h01);
    do_tok("R8 OUT stalled", K_OUT, 2);
    do_tok("R8 IN stalled", K_IN, 2);
    do_cmd("R13 stall bit", 'h41, 2, 0);
    do_cmd("R8 stall ep0", 'h40, 0, 'h01);
    do_tok("R8 OUT ep0 stalled", K_OUT, 0);
    do_tok("R8 SETUP on stalled ep0", K_SET, 0);
    do_cmd("R8 stall cleared", 'h41, 0, 0);
    do_cmd("R8 free ep0", 'hF2, 0, 0);
    // R9 conditional stall
    do_cmd("R9 cond stall ep0", 'h40, 0, 'h80);
    do_tok("R9 IN ep0 halted", K_IN, 0);
    do_tok("R9 OUT ep0 halted", K_OUT, 0);
    do_tok("R9 SETUP releases", K_SET, 0);
    do_tok("R9 IN ep0 NAK", K_IN, 0);
    do_cmd("R9 clear pending", 'h41, 0, 0);
    do_tok("R9 IN ep0 halted again", K_IN, 0);
    do_cmd("R9 cond stall bit 7 ignored on ep1", 'h40, 1, 'h80);
    do_cmd("R9 drop cond stall", 'h40, 0, 'h00);
    do_tok("R9 IN ep0 normal", K_IN, 0);
    // R11 rate feedback
    do_cmd("R11 rate feedback ep1", 'h40, 1, 'h40);
    do_cmd("R11 arm", 'hFA, 1, 0);
    do_tok("R11 IN DATA0", K_IN, 1);
    do_cmd("R11 arm again", 'hFA, 1, 0);
    do_tok("R11 IN still DATA0", K_IN, 1);
    do_cmd("R11 free ep1", 'hF2, 1, 0);
    do_tok("R11 OUT DATA0", K_OUT, 1);
    do_cmd("R11 back to toggle", 'h40, 1, 'h00);
    do_cmd("R11 arm toggle", 'hFA, 1, 0);
    do_tok("R11 toggle kept", K_IN, 1);
    // R12 timing and other opcodes
    do_cmd("R12 unknown opcode", 'h77, 1, 0);
    do_tok("R12 reserved kind", 3, 1);
    idle("R12 idle");
    do_tok("R12 back to back a", K_IN, 2);
    do_tok("R12 back to back b", K_OUT, 3);
    idle("R12 final idle");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule